// File: doc/BRIEF.md
# Atomic-Launch Message Network Interface

This block connects a processor's register bus to a flit-based network and keeps injection all-or-nothing. Software composes an outgoing message by writing words into a bank of staging registers. Those writes never reach the network. A single launch command then sends the staged words as one head-to-tail flit stream. Until that command is given, software can read the staged words back to save them, or clear them with a cancel, without ever holding a network channel.

On the receive side, one incoming message is gathered into a receive buffer. When its tail arrives, a pending flag is set. The flag can be polled, or it can raise an interrupt when the interrupt enable is on. Software reads the words and then issues a dispose command, which frees the buffer for the next message. Reception does not depend on the transmit side, so the node keeps draining the network while its own message is stalled.

Bus map. Address bits [ADDR_W-1:ADDR_W-2] select a space: 00 is the staging words, 01 is the receive words, and 10 is control. The low IDX_W bits give the word index. Control index 0 is the command register: bit0 launch, bit1 cancel, bit2 dispose, and bits [8+:LEN_W] hold the length in words. Control index 1 is status: bit0 busy, bit1 receive pending, bit2 interrupt enable (writable), and bits [8+:LEN_W] hold the received length. Reads are combinational and have no side effects.

Top module: `msg_nif`

## Requirements
- R1: After reset, no flit is offered, in_ready_o is high, irq_o is low, the status register reads zero and every staging word reads zero.
- R2: Writes to the staging space never produce a flit, and every staging word reads back the last value written.
- R3: A launch with length L sends staging words 0 to L-1 in order, one per accepted flit. The head flag is set on word 0 and the tail flag on word L-1. While out_ready_i is low, the offered flit stays unchanged.
- R4: While a message is being sent, status bit0 reads 1. A launch, a cancel or a staging write in that period is ignored.
- R5: A cancel clears all staging words to zero and sends nothing. A command with both the launch and cancel bits set acts as a cancel only.
- R6: A launch whose length is 0 or greater than WORDS is ignored.
- R7: Received flits are stored from index 0. When the tail flit is accepted, status bit1 goes to 1 and the status length field holds the word count. The stored words can be read from the receive space.
- R8: in_ready_o is low while a received message is pending. A dispose frees the buffer and raises in_ready_o again. A dispose with nothing pending has no effect.
- R9: irq_o equals the pending flag ANDed with the interrupt enable (status bit2). The pending flag itself is visible to polling regardless of the enable.
- R10: Reception proceeds while a transmission is stalled by the network.
- R11: A flit with the head flag restarts reception at index 0, discarding any unfinished message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_req_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | Write when high |
| bus_addr_i | input | ADDR_W | Space and word index |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Combinational read data |
| irq_o | output | 1 | Receive interrupt |
| out_valid_o | output | 1 | Outgoing flit valid |
| out_ready_i | input | 1 | Network accepts outgoing flit |
| out_data_o | output | DATA_W | Outgoing flit payload |
| out_head_o | output | 1 | Outgoing flit is head |
| out_tail_o | output | 1 | Outgoing flit is tail |
| in_valid_i | input | 1 | Incoming flit valid |
| in_ready_o | output | 1 | Interface accepts incoming flit |
| in_data_i | input | DATA_W | Incoming flit payload |
| in_head_i | input | 1 | Incoming flit is head |
| in_tail_i | input | 1 | Incoming flit is tail |

## Verification
The bench stages words with the network ready and watches the output each cycle. A design that streamed words as they were written would show flits before any launch. It stalls the network mid-message and tries a second launch, a staging write and a cancel. A design that accepted any of them would corrupt the flit in flight or restart the stream. It sends a length of zero and a length past the staging depth, and a command carrying both launch and cancel. A wrong length guard would emit a stream, and the wrong priority would inject a message that should have been dropped. On the receive side, it pushes a message while the transmit side is blocked. It offers flits while a message is pending and issues a dispose with nothing pending. It restarts a message with a second head flit. Tying reception to transmit state, overwriting a pending message, or failing to realign on a head would each show up as a mismatch.

// File: rtl/nif_pkg.sv
package nif_pkg;
  typedef enum logic [1:0] {
    SP_STAGE = 2'b00,
    SP_RXBUF = 2'b01,
    SP_CTRL  = 2'b10
  } nif_space_e;

  localparam int CTRL_CMD    = 0;
  localparam int CTRL_STAT   = 1;
  localparam int CMD_LAUNCH  = 0;
  localparam int CMD_CANCEL  = 1;
  localparam int CMD_DISPOSE = 2;
  localparam int ST_BUSY     = 0;
  localparam int ST_RXV      = 1;
  localparam int ST_IRQEN    = 2;
  localparam int LEN_LSB     = 8;
endpackage

// File: rtl/nif_tx.sv
module nif_tx #(
  parameter int DATA_W = 32,
  parameter int WORDS  = 4,
  localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int LEN_W = $clog2(WORDS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stage_we_i,
  input  logic [IDX_W-1:0]  stage_idx_i,
  input  logic [DATA_W-1:0] stage_wdata_i,
  input  logic              launch_i,
  input  logic              cancel_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              busy_o,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_head_o,
  output logic              out_tail_o
);
  logic [DATA_W-1:0] stage_q [WORDS];
  logic              busy_q;
  logic [IDX_W-1:0]  ptr_q, last_q;
  logic [LEN_W-1:0]  len_m1;
  logic              cancel_ok, launch_ok, fire;

  assign cancel_ok = cancel_i & ~busy_q;
  assign launch_ok = launch_i & ~cancel_i & ~busy_q &
                     (len_i != '0) & (len_i <= LEN_W'(WORDS));
  assign len_m1    = len_i - LEN_W'(1);
  assign fire      = busy_q & out_ready_i;

  for (genvar i = 0; i < WORDS; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                       stage_q[i] <= '0;
      else if (cancel_ok)                                stage_q[i] <= '0;
      else if (stage_we_i && !busy_q && stage_idx_i == IDX_W'(i))
                                                         stage_q[i] <= stage_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      ptr_q  <= '0;
      last_q <= '0;
    end else if (launch_ok) begin
      busy_q <= 1'b1;
      ptr_q  <= '0;
      last_q <= len_m1[IDX_W-1:0];
    end else if (fire) begin
      if (ptr_q == last_q) busy_q <= 1'b0;
      else                 ptr_q  <= ptr_q + IDX_W'(1);
    end
  end

  assign rd_data_o   = stage_q[rd_idx_i];
  assign busy_o      = busy_q;
  assign out_valid_o = busy_q;
  assign out_data_o  = stage_q[ptr_q];
  assign out_head_o  = (ptr_q == '0);
  assign out_tail_o  = (ptr_q == last_q);

  a_r3_hold_under_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o) && $stable(out_tail_o));
  a_r3_first_is_head: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_valid_o) |-> out_head_o);
  a_r3_tail_ends_stream: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_ready_i && out_tail_o |=> !out_valid_o);
  a_r6_zero_len_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && launch_i && len_i == '0 |=> !out_valid_o);
endmodule

// File: rtl/nif_rx.sv
module nif_rx #(
  parameter int DATA_W = 32,
  parameter int WORDS  = 4,
  localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int LEN_W = $clog2(WORDS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              in_head_i,
  input  logic              in_tail_i,
  output logic              in_ready_o,
  input  logic              dispose_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              msg_valid_o,
  output logic [LEN_W-1:0]  msg_len_o
);
  logic [DATA_W-1:0] buf_q [WORDS];
  logic              valid_q;
  logic [IDX_W-1:0]  wptr_q, widx;
  logic [LEN_W-1:0]  len_q;
  logic              accept;

  assign accept = in_valid_i & ~valid_q;
  assign widx   = in_head_i ? '0 : wptr_q;

  for (genvar i = 0; i < WORDS; i++) begin : g_buf
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             buf_q[i] <= '0;
      else if (accept && widx == IDX_W'(i))    buf_q[i] <= in_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      wptr_q  <= '0;
      len_q   <= '0;
    end else if (accept) begin
      if (in_tail_i) begin
        valid_q <= 1'b1;
        len_q   <= LEN_W'(widx) + LEN_W'(1);
        wptr_q  <= '0;
      end else begin
        // saturate on oversize messages: the last slot is overwritten
        wptr_q  <= (widx == IDX_W'(WORDS - 1)) ? widx : widx + IDX_W'(1);
      end
    end else if (dispose_i && valid_q) begin
      valid_q <= 1'b0;
    end
  end

  assign in_ready_o  = ~valid_q;
  assign rd_data_o   = buf_q[rd_idx_i];
  assign msg_valid_o = valid_q;
  assign msg_len_o   = len_q;

  a_r7_tail_sets_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o && in_tail_i |=> msg_valid_o);
  a_r8_pending_until_dispose: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o && !dispose_i |=> msg_valid_o && $stable(msg_len_o));
endmodule

// File: rtl/msg_nif.sv
module msg_nif #(
  parameter int DATA_W  = 32,
  parameter int WORDS   = 4,
  localparam int IDX_W  = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int LEN_W  = $clog2(WORDS + 1),
  localparam int ADDR_W = IDX_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_head_o,
  output logic              out_tail_o,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              in_head_i,
  input  logic              in_tail_i
);
  import nif_pkg::*;

  logic [1:0]        space;
  logic [IDX_W-1:0]  idx;
  logic              wr, cmd_we, stat_we;
  logic              tx_busy, rx_valid, irq_en_q;
  logic [LEN_W-1:0]  rx_len;
  logic [DATA_W-1:0] tx_rd, rx_rd, status;

  assign space   = bus_addr_i[ADDR_W-1 -: 2];
  assign idx     = bus_addr_i[IDX_W-1:0];
  assign wr      = bus_req_i & bus_we_i;
  assign cmd_we  = wr && space == SP_CTRL && idx == IDX_W'(CTRL_CMD);
  assign stat_we = wr && space == SP_CTRL && idx == IDX_W'(CTRL_STAT);

  nif_tx #(.DATA_W(DATA_W), .WORDS(WORDS)) u_tx (
    .clk_i, .rst_ni,
    .stage_we_i   (wr && space == SP_STAGE),
    .stage_idx_i  (idx),
    .stage_wdata_i(bus_wdata_i),
    .launch_i     (cmd_we & bus_wdata_i[CMD_LAUNCH]),
    .cancel_i     (cmd_we & bus_wdata_i[CMD_CANCEL]),
    .len_i        (bus_wdata_i[LEN_LSB +: LEN_W]),
    .rd_idx_i     (idx),
    .rd_data_o    (tx_rd),
    .busy_o       (tx_busy),
    .out_valid_o, .out_ready_i, .out_data_o, .out_head_o, .out_tail_o
  );

  nif_rx #(.DATA_W(DATA_W), .WORDS(WORDS)) u_rx (
    .clk_i, .rst_ni,
    .in_valid_i, .in_data_i, .in_head_i, .in_tail_i, .in_ready_o,
    .dispose_i  (cmd_we & bus_wdata_i[CMD_DISPOSE]),
    .rd_idx_i   (idx),
    .rd_data_o  (rx_rd),
    .msg_valid_o(rx_valid),
    .msg_len_o  (rx_len)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      irq_en_q <= 1'b0;
    else if (stat_we) irq_en_q <= bus_wdata_i[ST_IRQEN];
  end

  always_comb begin
    status                      = '0;
    status[ST_BUSY]             = tx_busy;
    status[ST_RXV]              = rx_valid;
    status[ST_IRQEN]            = irq_en_q;
    status[LEN_LSB +: LEN_W]    = rx_len;
  end

  always_comb begin
    bus_rdata_o = '0;
    unique case (space)
      SP_STAGE: bus_rdata_o = tx_rd;
      SP_RXBUF: bus_rdata_o = rx_rd;
      SP_CTRL:  if (idx == IDX_W'(CTRL_STAT)) bus_rdata_o = status;
      default:  bus_rdata_o = '0;
    endcase
  end

  assign irq_o = rx_valid & irq_en_q;

  a_r10_sink_while_sending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_busy && !out_ready_i && !rx_valid |-> in_ready_o);
  a_r9_irq_needs_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> rx_valid);
endmodule

// File: tb/msg_nif_bench.sv
module msg_nif_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int NW = 4;
  localparam int AW = 4;

  logic clk = 0, rst_n = 0;
  logic bus_req = 0, bus_we = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0, bus_rdata;
  logic irq, out_valid, out_ready = 1, out_head, out_tail;
  logic [DW-1:0] out_data;
  logic in_valid = 0, in_ready, in_head = 0, in_tail = 0;
  logic [DW-1:0] in_data = '0;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  msg_nif u_msg_nif (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_req_i(bus_req), .bus_we_i(bus_we), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .irq_o(irq),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_data_o(out_data),
    .out_head_o(out_head), .out_tail_o(out_tail),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_data_i(in_data),
    .in_head_i(in_head), .in_tail_i(in_tail)
  );

  // reference model
  logic [DW-1:0] m_stage [NW];
  logic [DW-1:0] m_rbuf [NW];
  logic [DW+1:0] m_q [$];
  bit m_busy, m_rxv, m_irqen;
  int m_rlen, m_wptr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NW; i++) begin m_stage[i] = '0; m_rbuf[i] = '0; end
      m_q.delete(); m_busy = 0; m_rxv = 0; m_irqen = 0; m_rlen = 0; m_wptr = 0;
    end else begin
      bit pb, pr;
      int sp, ix, ln, wi;
      pb = m_busy; pr = m_rxv;
      if (pb && out_ready) begin
        void'(m_q.pop_front());
        if (m_q.size() == 0) m_busy = 0;
      end
      if (in_valid && !pr) begin
        wi = in_head ? 0 : m_wptr;
        m_rbuf[wi] = in_data;
        if (in_tail) begin m_rxv = 1; m_rlen = wi + 1; m_wptr = 0; end
        else m_wptr = (wi == NW-1) ? wi : wi + 1;
      end
      if (bus_req && bus_we) begin
        sp = int'(bus_addr[3:2]); ix = int'(bus_addr[1:0]);
        ln = int'(bus_wdata[10:8]);
        if (sp == 0 && !pb) m_stage[ix] = bus_wdata;
        if (sp == 2 && ix == 1) m_irqen = bus_wdata[2];
        if (sp == 2 && ix == 0) begin
          if (bus_wdata[2] && pr) m_rxv = 0;
          if (bus_wdata[1] && !pb) begin
            for (int i = 0; i < NW; i++) m_stage[i] = '0;
          end else if (bus_wdata[0] && !pb && ln >= 1 && ln <= NW) begin
            for (int i = 0; i < ln; i++) m_q.push_back({i == 0, i == ln-1, m_stage[i]});
            m_busy = 1;
          end
        end
      end
    end
  end

  function automatic logic [DW-1:0] m_read(logic [AW-1:0] a);
    logic [DW-1:0] r = '0;
    case (a[3:2])
      2'b00: r = m_stage[a[1:0]];
      2'b01: r = m_rbuf[a[1:0]];
      2'b10: if (a[1:0] == 2'd1) begin
        r[0] = m_busy; r[1] = m_rxv; r[2] = m_irqen; r[10:8] = 3'(m_rlen);
      end
      default: r = '0;
    endcase
    return r;
  endfunction

  // per-cycle comparison
  always @(negedge clk) if (rst_n && !done) begin
    logic [DW+1:0] e;
    n_chk++;
    if (out_valid !== m_busy) begin
      n_fail++; $display("FAIL R2/R3 out_valid act=%0b exp=%0b t=%0t", out_valid, m_busy, $time);
    end else if (m_busy) begin
      e = m_q[0];
      if ({out_head, out_tail, out_data} !== e) begin
        n_fail++; $display("FAIL R3 flit act=%h exp=%h t=%0t", {out_head, out_tail, out_data}, e, $time);
      end
    end
    n_chk++;
    if (in_ready !== !m_rxv) begin
      n_fail++; $display("FAIL R8 in_ready act=%0b exp=%0b t=%0t", in_ready, !m_rxv, $time);
    end
    n_chk++;
    if (irq !== (m_rxv & m_irqen)) begin
      n_fail++; $display("FAIL R9 irq act=%0b exp=%0b t=%0t", irq, m_rxv & m_irqen, $time);
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    bus_req = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 0; bus_we = 0;
  endtask

  task automatic cmd(input bit launch, input bit cancel, input bit dispose, input int len);
    logic [DW-1:0] d = '0;
    d[0] = launch; d[1] = cancel; d[2] = dispose; d[10:8] = 3'(len);
    wr(4'b1000, d);
  endtask

  task automatic rd_chk(input logic [AW-1:0] a, input string tag);
    logic [DW-1:0] e;
    bus_addr = a; #1;
    e = m_read(a);
    n_chk++;
    if (bus_rdata !== e) begin
      n_fail++; $display("FAIL %s read addr=%h act=%h exp=%h", tag, a, bus_rdata, e);
    end
    @(negedge clk);
  endtask

  task automatic push(input logic [DW-1:0] d, input bit h, input bit t);
    bit ok = 0;
    in_valid = 1; in_data = d; in_head = h; in_tail = t;
    while (!ok) begin ok = in_ready; @(negedge clk); end
    in_valid = 0; in_head = 0; in_tail = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    idle(3); rst_n = 1; idle(1);
    // R1 reset state
    rd_chk(4'b1001, "R1"); rd_chk(4'b0000, "R1"); rd_chk(4'b0011, "R1");
    // R2 staging writes produce no flits, read back
    for (int i = 0; i < NW; i++) wr(AW'(i), 32'hA000_0000 + DW'(i));
    idle(2);
    for (int i = 0; i < NW; i++) rd_chk(AW'(i), "R2");
    // R3 launch len 3 with ready
    cmd(1, 0, 0, 3); idle(5);
    // R3 backpressure, full length
    out_ready = 0; cmd(1, 0, 0, 4); idle(3);
    // R4 launch, stage write, cancel ignored while busy
    rd_chk(4'b1001, "R4");
    cmd(1, 0, 0, 2); wr(4'b0001, 32'hDEAD_BEEF); cmd(0, 1, 0, 0);
    rd_chk(4'b0001, "R4");
    out_ready = 1; idle(1); out_ready = 0; idle(2); out_ready = 1; idle(5);
    rd_chk(4'b1001, "R4");
    // R5 cancel clears; launch+cancel acts as cancel
    cmd(0, 1, 0, 0);
    for (int i = 0; i < NW; i++) rd_chk(AW'(i), "R5");
    wr(4'b0000, 32'h1234_5678); wr(4'b0001, 32'h8765_4321);
    cmd(1, 1, 0, 2); idle(3);
    rd_chk(4'b0000, "R5");
    // R6 bad lengths ignored
    wr(4'b0000, 32'h0000_00C0); wr(4'b0001, 32'h0000_00C1);
    cmd(1, 0, 0, 0); idle(3); cmd(1, 0, 0, 5); idle(3);
    rd_chk(4'b1001, "R6");
    // R7 receive, polling (irq disabled) R9
    push(32'hB0, 1, 0); push(32'hB1, 0, 0); push(32'hB2, 0, 1);
    idle(1);
    rd_chk(4'b1001, "R7");
    for (int i = 0; i < 3; i++) rd_chk(AW'(4 + i), "R7");
    // R8 flits held off while pending
    in_valid = 1; in_data = 32'hEE; in_head = 1; in_tail = 1; idle(3);
    in_valid = 0; in_head = 0; in_tail = 0;
    rd_chk(4'b0100, "R8");
    // R9 enable interrupt with message pending
    wr(4'b1001, 32'h4); idle(1);
    rd_chk(4'b1001, "R9");
    // R8 dispose then dispose with nothing pending
    cmd(0, 0, 1, 0); idle(1); cmd(0, 0, 1, 0); idle(1);
    rd_chk(4'b1001, "R8");
    // R10 receive while transmit stalled
    wr(4'b0000, 32'h11); wr(4'b0001, 32'h22);
    out_ready = 0; cmd(1, 0, 0, 2); idle(1);
    push(32'hC0, 1, 0); push(32'hC1, 0, 1); idle(1);
    rd_chk(4'b1001, "R10"); rd_chk(4'b0101, "R10");
    out_ready = 1; idle(4);
    cmd(0, 0, 1, 0); idle(1);
    // R11 head restarts the message
    push(32'hD0, 1, 0); push(32'hD1, 0, 0); push(32'hD9, 1, 1); idle(1);
    rd_chk(4'b1001, "R11"); rd_chk(4'b0100, "R11");
    cmd(0, 0, 1, 0); idle(2);
    finish_run();
  end
endmodule